// File: doc/BRIEF.md
# Framed Byte-Stream Register Command Engine

This block sits between a byte-wide host link and an internal register bus. The host sends framed commands as a stream of bytes. The engine finds each frame, checks that it ends where it should, and runs it as a single-word access on the register bus. The bus has a 16-bit address and 32-bit data by default. The engine then sends back a framed response whose length depends on the outcome. The link side uses a valid/ready handshake in each direction. The bus side is a plain chip-select, write-enable, address, write-data and read-data interface.

Every command frame opens with the byte 0x55. A command byte and two address bytes follow, high address byte first. A write frame then carries four data bytes, most significant first. The frame closes with 0xAA. Reset frames and unrecognised commands carry the address bytes too, so every frame except a write is five bytes long.

Responses use the opposite markers: they open with 0xAA and close with 0x55. The engine takes no new command until the current response has left, so the host can keep the stream flowing and rely on the input handshake for pacing.

Top module: `frame_cmd_engine`

## Requirements
- R1: A byte that arrives while no start marker 0x55 is pending is consumed and dropped. It causes no bus access and no response byte.
- R2: A read frame (0x55, 0x10, addr-high, addr-low, 0xAA) produces exactly one bus cycle with chip-select high and write-enable low. The address is formed as {addr-high, addr-low}.
- R3: Read data is sampled in the cycle right after the single chip-select cycle. The response is the 9 bytes 0xAA, 0x7F, addr-high, addr-low, data[31:24], data[23:16], data[15:8], data[7:0], 0x55.
- R4: A write frame (0x55, 0x11, addr-high, addr-low, d0, d1, d2, d3, 0xAA) raises chip-select and write-enable together for exactly one cycle. The write data is {d0, d1, d2, d3}, so d3 lands in bits 7:0.
- R5: A write is answered with the 5 bytes 0xAA, 0x7E, addr-high, addr-low, 0x55.
- R6: A reset frame (command 0x01) is answered with the 3 bytes 0xAA, 0x7D, 0x55 and makes no bus access.
- R7: A frame with a well-placed 0xAA end marker but any command other than 0x10, 0x11 or 0x01 is answered with 0xAA, 0xFE, the command byte, 0x55. It makes no bus access.
- R8: A frame whose byte at the end-marker position is not 0xAA is answered with 0xAA, 0xFD, the command byte, 0x55. It makes no bus access, even when it is a write. The engine then goes back to hunting for a start marker.
- R9: The input ready stays low from the transfer of a frame's last byte until the last response byte has been transferred. It is high at every other time.
- R10: While the output valid is high and the output ready is low, the output byte and the output valid hold their values.
- R11: While reset is asserted and in the first cycle after it, the input ready is high, the output valid is low and chip-select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | Incoming byte is present |
| rx_ready | output | 1 | Engine accepts the incoming byte |
| tx_data | output | 8 | Outgoing response byte |
| tx_valid | output | 1 | Outgoing byte is present |
| tx_ready | input | 1 | Link takes the outgoing byte |
| bus_cs | output | 1 | Register bus chip-select, one cycle per access |
| bus_we | output | 1 | Register bus write-enable, high only with chip-select |
| bus_addr | output | 16 | Register bus word address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid the cycle after chip-select |

## Verification
The assertions take for granted that the link side obeys the handshake rules. An offered input byte stays put until it is taken. The output ready can drop at any time. The register slave returns read data in the cycle after chip-select, and it does not matter what it drives at other times. The stimulus changes inputs only right after a clock edge. It holds each byte until the engine takes it. It toggles the output ready pseudo-randomly in some phases. It also models a slave that drives garbage read data outside the one valid cycle, so a read sampled a cycle early or late shows up as a data mismatch.

// File: rtl/fce_pkg.sv
// Package: shared marker bytes, command/response codes and the decoded
// frame kind used by the framed command engine.
package fce_pkg;

    // Command stream markers and command codes
    localparam logic [7:0] CMD_SOF  = 8'h55;
    localparam logic [7:0] CMD_EOF  = 8'hAA;
    localparam logic [7:0] OP_READ  = 8'h10;
    localparam logic [7:0] OP_WRITE = 8'h11;
    localparam logic [7:0] OP_RESET = 8'h01;

    // Response stream markers and result codes
    localparam logic [7:0] RSP_SOF     = 8'hAA;
    localparam logic [7:0] RSP_EOF     = 8'h55;
    localparam logic [7:0] RC_READ     = 8'h7F;
    localparam logic [7:0] RC_WRITE    = 8'h7E;
    localparam logic [7:0] RC_RESET    = 8'h7D;
    localparam logic [7:0] RC_UNKNOWN  = 8'hFE;
    localparam logic [7:0] RC_MALFORM  = 8'hFD;

    // Outcome of a parsed frame
    typedef enum logic [2:0] {
        KIND_READ    = 3'd0,
        KIND_WRITE   = 3'd1,
        KIND_RESET   = 3'd2,
        KIND_UNKNOWN = 3'd3,
        KIND_MALFORM = 3'd4
    } kind_e;

endpackage

// File: rtl/fce_rx_parser.sv
// Module: fce_rx_parser
// Hunts for a start marker, collects the command byte, the address bytes
// (high first) and, for writes, the data bytes (most significant first).
// It then judges the byte at the end-marker position. When a frame is
// complete it raises req_valid for one cycle and holds the decoded frame
// stable, with its input stalled, until resp_done reports that the whole
// response has left.
// Assumes: ADDR_W and DATA_W are multiples of 8; resp_done only arrives
// while the parser is waiting.
module fce_rx_parser
    import fce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              resp_done,
    output logic              req_valid,
    output kind_e             req_kind,
    output logic [7:0]        req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int MAX_BYTES  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BYTES - 1);

    typedef enum logic [2:0] {
        P_HUNT, P_OP, P_ADDR, P_DATA, P_END, P_WAIT
    } pstate_e;

    pstate_e          state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    kind_e            end_kind;

    assign rx_ready = (state_q != P_WAIT);
    assign take     = rx_valid && rx_ready;

    // Decide the outcome from the byte that sits at the end-marker position
    always_comb begin
        if (rx_data != CMD_EOF) begin
            end_kind = KIND_MALFORM;
        end else begin
            case (req_cmd)
                OP_READ:  end_kind = KIND_READ;
                OP_WRITE: end_kind = KIND_WRITE;
                OP_RESET: end_kind = KIND_RESET;
                default:  end_kind = KIND_UNKNOWN;
            endcase
        end
    end

    // Frame-walking state machine with field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= P_HUNT;
            cnt_q     <= '0;
            req_valid <= 1'b0;
            req_kind  <= KIND_READ;
            req_cmd   <= 8'h00;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            req_valid <= 1'b0;
            case (state_q)
                P_HUNT: begin
                    if (take && rx_data == CMD_SOF) begin
                        state_q <= P_OP;
                    end
                end
                P_OP: begin
                    if (take) begin
                        req_cmd <= rx_data;
                        cnt_q   <= '0;
                        state_q <= P_ADDR;
                    end
                end
                P_ADDR: begin
                    if (take) begin
                        req_addr <= (req_addr << 8) | ADDR_W'(rx_data);
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= (req_cmd == OP_WRITE) ? P_DATA : P_END;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                P_DATA: begin
                    if (take) begin
                        req_wdata <= (req_wdata << 8) | DATA_W'(rx_data);
                        if (cnt_q == DATA_LAST) begin
                            cnt_q   <= '0;
                            state_q <= P_END;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                P_END: begin
                    if (take) begin
                        req_kind  <= end_kind;
                        req_valid <= 1'b1;
                        state_q   <= P_WAIT;
                    end
                end
                P_WAIT: begin
                    if (resp_done) begin
                        state_q <= P_HUNT;
                    end
                end
                default: state_q <= P_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/fce_bus_access.sv
// Module: fce_bus_access
// Turns a decoded read or write request into a single chip-select cycle
// on the register bus. A read samples the slave's data in the following
// cycle. Requests that need no bus access are passed on at once. rsp_valid
// pulses once per request when the result is ready.
// Assumes: a new request only arrives after the previous response is out.
module fce_bus_access
    import fce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  kind_e             req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef enum logic [1:0] {
        B_IDLE, B_ACCESS, B_CAPTURE
    } bstate_e;

    bstate_e st_q;
    logic    wr_q;

    assign bus_cs = (st_q == B_ACCESS);
    assign bus_we = bus_cs && wr_q;

    // Sequence one bus cycle per request and capture read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= B_IDLE;
            wr_q      <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                B_IDLE: begin
                    if (req_valid) begin
                        if (req_kind == KIND_READ || req_kind == KIND_WRITE) begin
                            st_q      <= B_ACCESS;
                            bus_addr  <= req_addr;
                            wr_q      <= (req_kind == KIND_WRITE);
                            bus_wdata <= (req_kind == KIND_WRITE) ? req_wdata : '0;
                        end else begin
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                B_ACCESS: begin
                    if (wr_q) begin
                        rsp_valid <= 1'b1;
                        st_q      <= B_IDLE;
                    end else begin
                        st_q <= B_CAPTURE;
                    end
                end
                B_CAPTURE: begin
                    rsp_rdata <= bus_rdata;
                    rsp_valid <= 1'b1;
                    st_q      <= B_IDLE;
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fce_tx_framer.sv
// Module: fce_tx_framer
// Builds the complete response image for a finished request in one cycle,
// stores it in a bank of byte slots, then streams the slots out through
// the valid/ready output. resp_done marks the transfer of the last byte.
// Assumes: rsp_valid never arrives while a response is still streaming.
module fce_tx_framer
    import fce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  kind_e             rsp_kind,
    input  logic [7:0]        rsp_cmd,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              resp_done
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int MAX_LEN    = 3 + ADDR_BYTES + DATA_BYTES;
    localparam int IDX_W      = $clog2(MAX_LEN + 1);

    logic [7:0]       img     [MAX_LEN];
    logic [IDX_W-1:0] img_len;
    logic [7:0]       slot_w  [MAX_LEN];
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    logic             active_q;
    logic             last_byte;

    // Assemble the response image for the finished request
    always_comb begin
        for (int i = 0; i < MAX_LEN; i++) begin
            img[i] = 8'h00;
        end
        img[0]  = RSP_SOF;
        img_len = IDX_W'(4);
        case (rsp_kind)
            KIND_READ: begin
                img[1] = RC_READ;
                for (int a = 0; a < ADDR_BYTES; a++) begin
                    img[2 + a] = rsp_addr[(ADDR_BYTES - 1 - a) * 8 +: 8];
                end
                for (int d = 0; d < DATA_BYTES; d++) begin
                    img[2 + ADDR_BYTES + d] = rsp_rdata[(DATA_BYTES - 1 - d) * 8 +: 8];
                end
                img[2 + ADDR_BYTES + DATA_BYTES] = RSP_EOF;
                img_len = IDX_W'(MAX_LEN);
            end
            KIND_WRITE: begin
                img[1] = RC_WRITE;
                for (int a = 0; a < ADDR_BYTES; a++) begin
                    img[2 + a] = rsp_addr[(ADDR_BYTES - 1 - a) * 8 +: 8];
                end
                img[2 + ADDR_BYTES] = RSP_EOF;
                img_len = IDX_W'(3 + ADDR_BYTES);
            end
            KIND_RESET: begin
                img[1]  = RC_RESET;
                img[2]  = RSP_EOF;
                img_len = IDX_W'(3);
            end
            KIND_UNKNOWN: begin
                img[1] = RC_UNKNOWN;
                img[2] = rsp_cmd;
                img[3] = RSP_EOF;
            end
            default: begin
                img[1] = RC_MALFORM;
                img[2] = rsp_cmd;
                img[3] = RSP_EOF;
            end
        endcase
    end

    // One register per response byte, loaded when a result arrives
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
        logic [7:0] byte_q;
        // Capture this slot of the image
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= 8'h00;
            end else if (rsp_valid) begin
                byte_q <= img[g];
            end
        end
        assign slot_w[g] = byte_q;
    end

    assign last_byte = (idx_q == len_q - IDX_W'(1));
    assign tx_valid  = active_q;
    assign tx_data   = slot_w[idx_q];
    assign resp_done = active_q && tx_ready && last_byte;

    // Walk through the stored bytes as the link takes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
        end else if (rsp_valid) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            len_q    <= img_len;
        end else if (active_q && tx_ready) begin
            if (last_byte) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_cmd_engine.sv
// Module: frame_cmd_engine (top)
// Framed byte-stream command engine: it parses read, write and reset
// frames from the input byte stream, performs single-word register bus
// accesses, and returns framed responses on the output byte stream. The
// chain is parser -> bus sequencer -> response framer, and the parser
// stays stalled until the framer reports that the response has left.
// Assumes: the link keeps an offered byte stable until it is accepted;
// the slave drives read data in the cycle after chip-select.
module frame_cmd_engine
    import fce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              req_valid;
    kind_e             req_kind;
    logic [7:0]        req_cmd;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              resp_done;

    fce_rx_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .resp_done (resp_done),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    fce_bus_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    fce_tx_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .rsp_kind  (req_kind),
        .rsp_cmd   (req_cmd),
        .rsp_addr  (req_addr),
        .rsp_rdata (rsp_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .resp_done (resp_done)
    );

endmodule

// File: rtl/fce_checker.sv
// Module: fce_checker
// Port-level properties of the framed command engine, bound to the top.
// Assumes: the link and slave follow the handshake rules in the brief.
module fce_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       bus_cs,
    input logic       bus_we
);

    // R2/R4: every access is a lone chip-select cycle
    a_r2_cs_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> !bus_cs);

    // R4: write-enable never appears without chip-select
    a_r4_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_cs);

    // R9: input is stalled while a response is being sent
    a_r9_stall_during_reply: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    // R9: input is stalled while the bus is being accessed
    a_r9_stall_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |-> !rx_ready);

    // R10: an offered byte holds until taken
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3: every response opens with its start marker
    a_r3_reply_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == 8'hAA));

    // R11: state right after a reset cycle
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !bus_cs && rx_ready));

endmodule

bind frame_cmd_engine fce_checker u_fce_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .bus_cs   (bus_cs),
    .bus_we   (bus_we)
);

// File: tb/sim_frame_cmd_engine.sv
// Bench for frame_cmd_engine: a behavioural model fed by the observed
// input transfers predicts bus accesses and response bytes, and every
// clock the ports are compared against it.
module sim_frame_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        bus_cs;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'h0;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit bp_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] dflt(logic [15:0] a);
        return {a ^ 16'hC3A5, ~a};
    endfunction

    // Slave: registered read data, garbage outside the valid cycle
    logic [31:0] smem [logic [15:0]];
    always @(posedge clk) begin
        if (bus_cs && !bus_we)
            bus_rdata <= smem.exists(bus_addr) ? smem[bus_addr] : dflt(bus_addr);
        else
            bus_rdata <= 32'hBAD0_0BAD;
        if (bus_cs && bus_we) smem[bus_addr] = bus_wdata;
    end

    // Reference model state
    logic [31:0] shadow [logic [15:0]];
    logic [7:0]  exp_tx[$];
    string       exp_tag[$];
    logic        exp_bwe[$];
    logic [15:0] exp_badr[$];
    logic [31:0] exp_bdat[$];
    bit          in_frame = 1'b0;
    logic [7:0]  frm[$];
    bit          hold_prev = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_rsp(logic [7:0] b, string tag);
        exp_tx.push_back(b);
        exp_tag.push_back(tag);
    endtask

    task automatic eval_frame();
        logic [7:0]  cmd;
        logic [15:0] a;
        logic [31:0] d;
        logic [31:0] rd;
        cmd = frm[0];
        a = {frm[1], frm[2]};
        if (frm[frm.size()-1] != 8'hAA) begin
            push_rsp(8'hAA, "R8"); push_rsp(8'hFD, "R8");
            push_rsp(cmd, "R8"); push_rsp(8'h55, "R8");
        end else if (cmd == 8'h10) begin
            rd = shadow.exists(a) ? shadow[a] : dflt(a);
            exp_bwe.push_back(1'b0); exp_badr.push_back(a); exp_bdat.push_back(32'h0);
            push_rsp(8'hAA, "R3"); push_rsp(8'h7F, "R3");
            push_rsp(a[15:8], "R3"); push_rsp(a[7:0], "R3");
            push_rsp(rd[31:24], "R3"); push_rsp(rd[23:16], "R3");
            push_rsp(rd[15:8], "R3"); push_rsp(rd[7:0], "R3");
            push_rsp(8'h55, "R3");
        end else if (cmd == 8'h11) begin
            d = {frm[3], frm[4], frm[5], frm[6]};
            shadow[a] = d;
            exp_bwe.push_back(1'b1); exp_badr.push_back(a); exp_bdat.push_back(d);
            push_rsp(8'hAA, "R5"); push_rsp(8'h7E, "R5");
            push_rsp(a[15:8], "R5"); push_rsp(a[7:0], "R5");
            push_rsp(8'h55, "R5");
        end else if (cmd == 8'h01) begin
            push_rsp(8'hAA, "R6"); push_rsp(8'h7D, "R6"); push_rsp(8'h55, "R6");
        end else begin
            push_rsp(8'hAA, "R7"); push_rsp(8'hFE, "R7");
            push_rsp(cmd, "R7"); push_rsp(8'h55, "R7");
        end
    endtask

    task automatic model_byte(logic [7:0] b);
        if (!in_frame) begin
            if (b == 8'h55) begin
                in_frame = 1'b1;
                frm.delete();
            end
        end else begin
            frm.push_back(b);
            if (frm.size() == ((frm[0] == 8'h11) ? 8 : 4)) begin
                eval_frame();
                in_frame = 1'b0;
            end
        end
    endtask

    // Per-clock comparison, sampled half a cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            // R9: stalled while a result is outstanding
            if (exp_tx.size() > 0)
                chk(rx_ready == 1'b0, "R9", "rx_ready while busy", 32'(rx_ready), 32'h0);
            else
                chk(rx_ready == 1'b1, "R9", "rx_ready while idle", 32'(rx_ready), 32'h1);
            // R10: held output byte
            if (hold_prev)
                chk(tx_valid && tx_data == prev_data, "R10", "held byte",
                    {23'h0, tx_valid, tx_data}, {24'h1, prev_data});
            hold_prev = tx_valid && !tx_ready;
            prev_data = tx_data;
            // R2/R4: bus accesses
            if (bus_cs) begin
                if (exp_bwe.size() == 0) begin
                    chk(1'b0, "R1", "unexpected bus access", {16'h0, bus_addr}, 32'h0);
                end else begin
                    chk(bus_we == exp_bwe[0], exp_bwe[0] ? "R4" : "R2", "bus we",
                        32'(bus_we), 32'(exp_bwe[0]));
                    chk(bus_addr == exp_badr[0], exp_bwe[0] ? "R4" : "R2", "bus addr",
                        {16'h0, bus_addr}, {16'h0, exp_badr[0]});
                    if (exp_bwe[0])
                        chk(bus_wdata == exp_bdat[0], "R4", "bus wdata", bus_wdata, exp_bdat[0]);
                    void'(exp_bwe.pop_front());
                    void'(exp_badr.pop_front());
                    void'(exp_bdat.pop_front());
                end
            end
            // Response bytes
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    chk(1'b0, "R1", "unexpected response byte", {24'h0, tx_data}, 32'h0);
                end else begin
                    chk(tx_data == exp_tx[0], exp_tag[0], "response byte",
                        {24'h0, tx_data}, {24'h0, exp_tx[0]});
                    void'(exp_tx.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            // Input transfers feed the model
            if (rx_valid && rx_ready) model_byte(rx_data);
        end
    end

    // Output backpressure driver
    initial begin
        forever begin
            @(posedge clk);
            #2;
            tx_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    task automatic send_byte(logic [7:0] b);
        rx_data = b;
        rx_valid = 1'b1;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        #2;
        rx_valid = 1'b0;
    endtask

    task automatic send_rd(logic [15:0] a);
        send_byte(8'h55); send_byte(8'h10);
        send_byte(a[15:8]); send_byte(a[7:0]); send_byte(8'hAA);
    endtask

    task automatic send_wr(logic [15:0] a, logic [31:0] d);
        send_byte(8'h55); send_byte(8'h11);
        send_byte(a[15:8]); send_byte(a[7:0]);
        send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
        send_byte(8'hAA);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_tx.size() > 0 || exp_bwe.size() > 0) @(negedge clk);
        repeat (4) @(posedge clk);
        #2;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(rx_ready == 1'b1, "R11", "rx_ready in reset", 32'(rx_ready), 32'h1);
        chk(tx_valid == 1'b0, "R11", "tx_valid in reset", 32'(tx_valid), 32'h0);
        chk(bus_cs == 1'b0, "R11", "bus_cs in reset", 32'(bus_cs), 32'h0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: stray bytes with no start marker pending
        send_byte(8'h00); send_byte(8'hAA); send_byte(8'h13);
        send_byte(8'hFF); send_byte(8'h7F);
        wait_idle();

        // R4/R5 write, then R2/R3 read back and read of untouched word
        send_wr(16'h1234, 32'hDEAD_BEEF);
        send_rd(16'h1234);
        send_rd(16'hABCD);
        wait_idle();

        // R6 reset frame, R7 unknown command
        send_byte(8'h55); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); send_byte(8'hAA);
        send_byte(8'h55); send_byte(8'h42); send_byte(8'h00); send_byte(8'h07); send_byte(8'hAA);
        wait_idle();

        // R8: bad end marker on a read and on a write, then recovery
        send_byte(8'h55); send_byte(8'h10); send_byte(8'h00); send_byte(8'h01); send_byte(8'h5A);
        send_byte(8'h55); send_byte(8'h11); send_byte(8'h00); send_byte(8'h02);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        send_byte(8'h77);
        send_rd(16'h0002);
        wait_idle();

        // Markers inside fields are plain data
        send_byte(8'h55); send_byte(8'h11); send_byte(8'h55); send_byte(8'hAA);
        send_byte(8'hAA); send_byte(8'h55); send_byte(8'h00); send_byte(8'hAA);
        send_byte(8'hAA);
        send_rd(16'h55AA);
        wait_idle();

        // R10 under backpressure, with stray bytes between frames
        bp_on = 1'b1;
        for (int i = 0; i < 12; i++) begin
            send_wr(16'(i * 16'h1111 + 16'h0F0F), 32'h8000_0001 ^ 32'(i * 32'h0101_0101));
            send_byte(8'h3C);
            send_rd(16'(i * 16'h1111 + 16'h0F0F));
            send_rd(16'hFFFF - 16'(i));
        end
        send_wr(16'hFFFF, 32'h8000_0001);
        send_rd(16'hFFFF);
        wait_idle();
        bp_on = 1'b0;
        wait_idle();

        chk(exp_tx.size() == 0, "R3", "responses left over", 32'(exp_tx.size()), 32'h0);
        chk(exp_bwe.size() == 0, "R2", "bus accesses left over", 32'(exp_bwe.size()), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule